// File: doc/BRIEF.md
# Descriptor DMA Channel Register File

This block is the register interface of a multi-channel descriptor DMA controller. A host reaches it through 32-bit word accesses. The upper address bits pick a channel, and each channel has a 256-byte window. Inside that window, each channel holds a control port, a status word, a command pointer, and three select words. The select words are used by the command sequencer when it evaluates interrupt, branch and wait conditions.

A control write does not store anything. It is applied to the status word as a masked update. The upper half of the data is the mask and the lower half is the value. After the merge, the block works out the side effects of RUN, WAKE and PAUSE on ACTIVE and DEAD, and applies the flush rules.

The block gives the sequencer three kinds of per-channel strobes:
- a kick when a control write leaves the channel active;
- a flush request;
- a descriptor fetch request when the command pointer is reloaded.

Command execution itself is done elsewhere.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register of every channel reads zero and no strobe is asserted.
- R2: Status layout is RUN=bit 15, PAUSE=14, FLUSH=13, WAKE=12, DEAD=11, ACTIVE=10, branch-taken=8, device status=7:0. A control write with data D merges `(D[15:0] & M) | (status & ~M)`, where M is D[31:16] restricted to bits 15:12 and 7:0. Mask bits outside that set leave the status unchanged, and direct writes to the status word are ignored.
- R3: After the merge, WAKE set forces ACTIVE to 1. RUN set forces ACTIVE to 1 and DEAD to 0. PAUSE set then forces ACTIVE to 0, overriding the other two.
- R4: When a control write takes RUN from 1 to 0, ACTIVE and DEAD are cleared. If FLUSH is set at that moment, a flush strobe is issued and FLUSH is cleared.
- R5: The cycle after a control write, the channel's kick strobe is high if the resulting ACTIVE is 1. Its flush strobe is high if FLUSH remains set in the result, or if R4 issued a flush.
- R6: Reading the control word (offset 0x00) or any unmapped offset returns zero.
- R7: A command pointer write (offset 0x08) is ignored while ACTIVE is 1. Otherwise the pointer stores the data with bits 3:0 cleared, and the descriptor fetch strobe pulses the next cycle.
- R8: The interrupt (0x0C), branch (0x10) and wait (0x14) select words store and read back all 32 bits. Status is at 0x04.
- R9: Address bits [AW-1:8] select the channel and bits 7:2 the word. An access to one channel leaves every other channel unchanged.
- R10: Kick, flush and fetch strobes are registered single-cycle pulses that only occur in the cycle after a write that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the current word access |
| reg_addr | input | AW | Byte address: channel in upper bits, word in 7:2 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| seq_kick | output | NCHAN | Per-channel start strobe to the sequencer |
| seq_flush | output | NCHAN | Per-channel flush strobe |
| desc_fetch | output | NCHAN | Per-channel descriptor fetch strobe |

## Verification
Directed sequences exercise the control semantics one at a time:
- RUN alone;
- PAUSE on top of RUN;
- WAKE without RUN;
- a mask that names non-writable bits;
- FLUSH while running, then RUN falling with FLUSH still set.

These separate the order of the derivation steps and the two flush paths. Command pointer writes with and without ACTIVE distinguish the lock from the alignment rule. Interleaved accesses to different channels expose channel-decode errors. A long pseudo-random phase then mixes masks, values and offsets across all channels, and a behavioural model checks the strobes and read data on every clock.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCHAN   = 4,
  parameter int CH_BITS = (NCHAN > 1) ? $clog2(NCHAN) : 1,
  parameter int AW      = CH_BITS + 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [NCHAN-1:0] seq_kick,
  output logic [NCHAN-1:0] seq_flush,
  output logic [NCHAN-1:0] desc_fetch
);
  localparam int B_RUN = 15, B_PAUSE = 14, B_FLUSH = 13, B_WAKE = 12;
  localparam int B_DEAD = 11, B_ACT = 10;
  localparam logic [15:0] WR_BITS = 16'hF0FF;
  localparam logic [5:0] W_CTRL = 6'd0, W_STAT = 6'd1, W_CPTR = 6'd2;
  localparam logic [5:0] W_ISEL = 6'd3, W_BSEL = 6'd4, W_WSEL = 6'd5;

  logic [CH_BITS-1:0] ch;
  logic [5:0]         widx;
  assign ch   = reg_addr[AW-1:8];
  assign widx = reg_addr[7:2];

  logic [15:0] stat_v [NCHAN];
  logic [31:0] cptr_v [NCHAN];
  logic [31:0] isel_v [NCHAN];
  logic [31:0] bsel_v [NCHAN];
  logic [31:0] wsel_v [NCHAN];

  for (genvar c = 0; c < NCHAN; c++) begin : g_ch
    logic [15:0] st_q, msk, nxt;
    logic [31:0] cp_q, is_q, bs_q, ws_q;
    logic        kick_q, flush_q, fetch_q, fl;
    logic        hit;

    assign hit = reg_wr && (int'(ch) == c);

    always_comb begin
      msk = reg_wdata[31:16] & WR_BITS;
      nxt = (reg_wdata[15:0] & msk) | (st_q & ~msk);
      fl  = 1'b0;
      if (nxt[B_WAKE]) nxt[B_ACT] = 1'b1;
      if (nxt[B_RUN]) begin
        nxt[B_ACT]  = 1'b1;
        nxt[B_DEAD] = 1'b0;
      end
      if (nxt[B_PAUSE]) nxt[B_ACT] = 1'b0;
      if (st_q[B_RUN] && !nxt[B_RUN]) begin
        nxt[B_ACT]  = 1'b0;
        nxt[B_DEAD] = 1'b0;
        if (nxt[B_FLUSH]) begin
          fl           = 1'b1;
          nxt[B_FLUSH] = 1'b0;
        end
      end
      if (nxt[B_FLUSH]) fl = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q <= '0; cp_q <= '0; is_q <= '0; bs_q <= '0; ws_q <= '0;
        kick_q <= 1'b0; flush_q <= 1'b0; fetch_q <= 1'b0;
      end else begin
        kick_q  <= 1'b0;
        flush_q <= 1'b0;
        fetch_q <= 1'b0;
        if (hit) begin
          case (widx)
            W_CTRL: begin
              st_q    <= nxt;
              kick_q  <= nxt[B_ACT];
              flush_q <= fl;
            end
            W_CPTR: if (!st_q[B_ACT]) begin
              cp_q    <= {reg_wdata[31:4], 4'b0000};
              fetch_q <= 1'b1;
            end
            W_ISEL: is_q <= reg_wdata;
            W_BSEL: bs_q <= reg_wdata;
            W_WSEL: ws_q <= reg_wdata;
            default: ;
          endcase
        end
      end
    end

    assign stat_v[c]     = st_q;
    assign cptr_v[c]     = cp_q;
    assign isel_v[c]     = is_q;
    assign bsel_v[c]     = bs_q;
    assign wsel_v[c]     = ws_q;
    assign seq_kick[c]   = kick_q;
    assign seq_flush[c]  = flush_q;
    assign desc_fetch[c] = fetch_q;
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCHAN; c++) begin
      if (int'(ch) == c) begin
        case (widx)
          W_STAT: reg_rdata = {16'h0000, stat_v[c]};
          W_CPTR: reg_rdata = cptr_v[c];
          W_ISEL: reg_rdata = isel_v[c];
          W_BSEL: reg_rdata = bsel_v[c];
          W_WSEL: reg_rdata = wsel_v[c];
          default: reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

module dma_chan_regs_chk #(
  parameter int NCHAN = 4,
  parameter int AW    = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [31:0]      reg_rdata,
  input logic [NCHAN-1:0] seq_kick,
  input logic [NCHAN-1:0] desc_fetch,
  input logic [15:0]      stat_v [NCHAN],
  input logic [31:0]      cptr_v [NCHAN]
);
  for (genvar c = 0; c < NCHAN; c++) begin : g_a
    // R5
    kick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_kick[c] |-> $past(reg_wr && reg_addr[7:2] == 6'd0 && int'(reg_addr[AW-1:8]) == c));
    // R7
    fetch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_fetch[c] |-> $past(reg_wr && reg_addr[7:2] == 6'd2 && int'(reg_addr[AW-1:8]) == c));
    // R3
    pause_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_v[c][14] && stat_v[c][10]));
    // R3
    run_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_v[c][15] && !stat_v[c][14]) |-> (stat_v[c][10] && !stat_v[c][11]));
    // R7
    cptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cptr_v[c][3:0] == 4'h0);
    // R7
    cptr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stat_v[c][10]) |-> $stable(cptr_v[c]));
  end
  // R6
  ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[7:2] == 6'd0) |-> (reg_rdata == 32'h0));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCHAN(NCHAN), .AW(AW)) u_chk (.*);

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  localparam int NCHAN = 4;
  localparam int AW    = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic [AW-1:0]    reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [NCHAN-1:0] seq_kick, seq_flush, desc_fetch;

  always #5 clk = ~clk;

  dma_chan_regs #(.NCHAN(NCHAN)) u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_kick(seq_kick),
    .seq_flush(seq_flush), .desc_fetch(desc_fetch));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit [15:0] m_st [NCHAN];
  bit [31:0] m_cp [NCHAN], m_is [NCHAN], m_bs [NCHAN], m_ws [NCHAN];
  bit [NCHAN-1:0] e_kick, e_flush, e_fetch;

  always @(posedge clk) begin
    e_kick = '0; e_flush = '0; e_fetch = '0;
    if (!rst_n) begin
      for (int c = 0; c < NCHAN; c++) begin
        m_st[c] = 0; m_cp[c] = 0; m_is[c] = 0; m_bs[c] = 0; m_ws[c] = 0;
      end
    end else if (reg_wr) begin
      int c, w;
      bit [15:0] mask, s, old;
      c = int'(reg_addr) / 256;
      w = (int'(reg_addr) % 256) / 4;
      if (w == 0) begin
        old  = m_st[c];
        mask = reg_wdata[31:16] & 16'hF0FF;
        s    = (reg_wdata[15:0] & mask) | (old & ~mask);
        if (s[12]) s[10] = 1;
        if (s[15]) begin s[10] = 1; s[11] = 0; end
        if (s[14]) s[10] = 0;
        if (old[15] && !s[15]) begin
          s[10] = 0; s[11] = 0;
          if (s[13]) begin e_flush[c] = 1; s[13] = 0; end
        end
        if (s[13]) e_flush[c] = 1;
        e_kick[c] = s[10];
        m_st[c] = s;
      end else if (w == 2) begin
        if (!m_st[c][10]) begin m_cp[c] = reg_wdata & ~32'hF; e_fetch[c] = 1; end
      end else if (w == 3) m_is[c] = reg_wdata;
      else if (w == 4) m_bs[c] = reg_wdata;
      else if (w == 5) m_ws[c] = reg_wdata;
    end
  end

  function automatic bit [31:0] exp_rd(bit [AW-1:0] a);
    int c = int'(a) / 256;
    int w = (int'(a) % 256) / 4;
    case (w)
      1: return {16'h0, m_st[c]};
      2: return m_cp[c];
      3: return m_is[c];
      4: return m_bs[c];
      5: return m_ws[c];
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(bit [AW-1:0] a);
    int w = (int'(a) % 256) / 4;
    case (w)
      1: return "R2";
      2: return "R7";
      3, 4, 5: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(seq_kick === e_kick, "R5 R10 kick", 32'(seq_kick), 32'(e_kick));
    chk(seq_flush === e_flush, "R4 R5 R10 flush", 32'(seq_flush), 32'(e_flush));
    chk(desc_fetch === e_fetch, "R7 R10 fetch", 32'(desc_fetch), 32'(e_fetch));
    chk(reg_rdata === exp_rd(reg_addr), rd_tag(reg_addr), reg_rdata, exp_rd(reg_addr));
  endtask

  task automatic cyc(bit we, int c, int w, bit [31:0] d);
    @(negedge clk);
    compare();
    reg_wr    = we;
    reg_addr  = AW'(c * 256 + w * 4);
    reg_wdata = d;
  endtask

  task automatic wr(int c, int w, bit [31:0] d);
    cyc(1, c, w, d);
  endtask

  task automatic rd_expect(int c, int w, bit [31:0] e, string tag);
    cyc(0, c, w, 0);
    @(negedge clk);
    chk(reg_rdata === e, tag, reg_rdata, e);
    compare();
    reg_wr = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    bit [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    for (int c = 0; c < NCHAN; c++)
      for (int w = 0; w < 8; w++) rd_expect(c, w, 0, "R1");
    chk(seq_kick == 0 && seq_flush == 0 && desc_fetch == 0, "R1 strobes",
        {seq_kick, seq_flush, desc_fetch}, 0);
    // R8 select registers
    wr(1, 3, 32'hDEADBEEF); wr(1, 4, 32'h0F0F1234); wr(1, 5, 32'h80000001);
    rd_expect(1, 3, 32'hDEADBEEF, "R8");
    rd_expect(1, 5, 32'h80000001, "R8");
    rd_expect(0, 3, 0, "R9 other channel");
    // R7 pointer alignment and fetch
    wr(2, 2, 32'h1234567F);
    @(negedge clk);
    chk(desc_fetch === 4'b0100, "R7 fetch", 32'(desc_fetch), 32'h4);
    compare();
    rd_expect(2, 2, 32'h12345670, "R7");
    // R3 RUN sets ACTIVE
    wr(2, 0, 32'hFFFF_8000);
    @(negedge clk);
    chk(seq_kick === 4'b0100, "R5 kick", 32'(seq_kick), 32'h4);
    compare();
    rd_expect(2, 1, 32'h8000 | 32'h0400, "R3");
    // R7 pointer locked while active
    wr(2, 2, 32'hAAAA0000);
    rd_expect(2, 2, 32'h12345670, "R7 locked");
    // R6 control reads zero; R2 status writes ignored
    rd_expect(2, 0, 0, "R6");
    wr(2, 1, 32'hFFFFFFFF);
    rd_expect(2, 1, 32'h8400, "R2 status write");
    // R2 mask on ACTIVE bit has no effect
    wr(2, 0, 32'h0400_0000);
    rd_expect(2, 1, 32'h8400, "R2 mask");
    // R2 device status bits
    wr(2, 0, 32'h00FF_00A5);
    rd_expect(2, 1, 32'h84A5, "R2 devstat");
    // R3 PAUSE overrides
    wr(2, 0, 32'h4000_4000);
    rd_expect(2, 1, 32'hC0A5, "R3 pause");
    wr(2, 0, 32'h4000_0000);
    rd_expect(2, 1, 32'h84A5, "R3 unpause");
    // R5 FLUSH while running
    wr(2, 0, 32'h2000_2000);
    @(negedge clk);
    chk(seq_flush === 4'b0100, "R5 flush", 32'(seq_flush), 32'h4);
    compare();
    // R4 RUN falls with FLUSH set
    wr(2, 0, 32'h8000_0000);
    @(negedge clk);
    chk(seq_flush === 4'b0100 && seq_kick === 0, "R4 flush", {seq_flush, seq_kick}, 8'h40);
    compare();
    rd_expect(2, 1, 32'h00A5, "R4 status");
    // R3 WAKE alone sets ACTIVE on channel 3
    wr(3, 0, 32'h1000_1000);
    rd_expect(3, 1, 32'h1400, "R3 wake");
    rd_expect(1, 1, 0, "R9 isolation");
    // random phase (R2 R3 R4 R5 R7 R8 R9 R10)
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc(lfsr[3] | lfsr[4], int'(lfsr[6:5]), int'(lfsr[10:8]) % 7,
          {lfsr[31:16] | (lfsr[11] ? 16'h0 : 16'hF000), lfsr[15:0]});
    end
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    finish_up();
  end
endmodule